// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast clock, taken from an oscillator under control, by a programmable total ratio of P×N+A. A dual-modulus prescaler is modelled as a counter on the fast clock, and it divides by either P or P+1. A swallow counter keeps the prescaler at P+1 for the first A prescaler cycles of each output period. A main counter then lets it run at P for the remaining N−A cycles. A one-cycle comparison pulse marks the end of every such period. A second counter divides a separate reference clock by R and produces a one-cycle reference pulse. Together the two pulses give the relation f_out = (P×N+A)·f_ref/R once a loop has settled.

The prescaler base P_BASE is a parameter, for example 8 for a low-band channel or 64 for a high-band channel. A select input chooses between the narrow pair (P_BASE) and the wide pair (2×P_BASE). Settings that are out of range are replaced by the smallest legal setting, and an error flag goes high while such a setting is present. A changed setting never cuts short the period in progress. It is picked up at the next reload.

Top module: `psd_divider`

## Requirements
- R1: With sel_narrow_i=1 the prescaler base is P_BASE, and the interval between successive fp_o pulses is P_BASE×N+A fast-clock cycles.
- R2: With sel_narrow_i=0 the prescaler base is 2×P_BASE, and the fp_o interval is 2×P_BASE×N+A fast-clock cycles.
- R3: With A=0 every prescaler cycle uses the base modulus, so the fp_o interval is exactly P×N.
- R4: The interval between successive fr_o pulses is R reference-clock cycles.
- R5: fp_o and fr_o are each high for exactly one cycle of their own clock.
- R6: New A, N, select and R values are taken only at a counter reload: the period in progress finishes with the old setting, and the following periods use the new setting.
- R7: An N below 3 is treated as 3, and cfg_err_o is high while it is applied.
- R8: An R below 3 is treated as 3, and cfg_err_o is high while it is applied.
- R9: An A that is not below the effective N is treated as 0 and raises cfg_err_o. A fully legal setting gives cfg_err_o=0.
- R10: While en_i is low, neither fp_o nor fr_o pulses and all counters stay at their reload values. After en_i rises, the pulses resume with the configured intervals.
- R11: During reset, fp_o and fr_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock (prescaler input) |
| ref_clk_i | input | 1 | Reference oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds both dividers at reload |
| sel_narrow_i | input | 1 | 1: base P_BASE, 0: base 2×P_BASE |
| a_i | input | A_W | Swallow count A |
| n_i | input | N_W | Main count N |
| r_i | input | R_W | Reference divide ratio R |
| fp_o | output | 1 | Divided comparison pulse (clk_i domain) |
| fr_o | output | 1 | Reference pulse (ref_clk_i domain) |
| cfg_err_o | output | 1 | Current setting is out of range and is being clamped |

## Verification
The comparison divider is tried with both modulus pairs, with a non-zero swallow count, with a zero swallow count and with a larger N. These runs separate the P and P+1 phases and show whether the swallow count is honoured at all. Each change of setting is made just after a pulse, so the expected intervals show whether the in-flight period is kept intact or truncated. Illegal N, A and R values are checked both on the error flag and on the clamped interval they produce. A disable window checks that both outputs stay silent, and that the intervals are correct again after the block is re-enabled.

// File: rtl/psd_pkg.sv
package psd_pkg;
  // smallest legal ratio for the main and reference counters
  localparam int unsigned MIN_DIV = 3;
endpackage

// File: rtl/psd_cfg_guard.sv
module psd_cfg_guard
  import psd_pkg::*;
#(
  parameter int unsigned A_W = 7,
  parameter int unsigned N_W = 11,
  parameter int unsigned R_W = 14
) (
  input  logic [A_W-1:0] a_i,
  input  logic [N_W-1:0] n_i,
  input  logic [R_W-1:0] r_i,
  output logic [A_W-1:0] a_o,
  output logic [N_W-1:0] n_o,
  output logic [R_W-1:0] r_o,
  output logic           err_o
);
  logic n_low, r_low, a_bad;

  always_comb begin
    n_low = n_i < N_W'(MIN_DIV);
    n_o   = n_low ? N_W'(MIN_DIV) : n_i;
    a_bad = N_W'(a_i) >= n_o;
    a_o   = a_bad ? '0 : a_i;
    r_low = r_i < R_W'(MIN_DIV);
    r_o   = r_low ? R_W'(MIN_DIV) : r_i;
    err_o = n_low | a_bad | r_low;
  end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned P_BASE = 8,
  localparam int unsigned PC_W  = $clog2(2 * P_BASE + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic wide_i,   // base 2*P_BASE instead of P_BASE
  input  logic plus_i,   // divide by base+1 in the next prescaler cycle
  output logic tick_o
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] mod_m1;

  always_comb begin
    mod_m1 = wide_i ? PC_W'(2 * P_BASE - 1) : PC_W'(P_BASE - 1);
    if (plus_i) mod_m1 = mod_m1 + PC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pc_q <= '0;
    else if (!run_i || pc_q == '0)  pc_q <= mod_m1;
    else                            pc_q <= pc_q - PC_W'(1);
  end

  assign tick_o = run_i && (pc_q == '0);
endmodule

// File: rtl/psd_swallow_ctl.sv
module psd_swallow_ctl
  import psd_pkg::*;
#(
  parameter int unsigned A_W = 7,
  parameter int unsigned N_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           tick_i,
  input  logic           narrow_i,
  input  logic [A_W-1:0] a_i,
  input  logic [N_W-1:0] n_i,
  output logic           wide_o,
  output logic           plus_o,
  output logic           wrap_o
);
  logic [A_W-1:0] a_q, a_d;
  logic [N_W-1:0] n_q, n_d;
  logic           wide_q, wide_d;
  logic           last, reload;

  always_comb begin
    last   = n_q == N_W'(1);
    reload = !run_i || (tick_i && last);
    a_d    = a_q;
    n_d    = n_q;
    wide_d = wide_q;
    if (reload) begin
      // setting is sampled only here: no truncated period
      a_d    = a_i;
      n_d    = n_i;
      wide_d = !narrow_i;
    end else if (tick_i) begin
      n_d = n_q - N_W'(1);
      a_d = (a_q == '0) ? '0 : a_q - A_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      n_q    <= N_W'(MIN_DIV);
      wide_q <= 1'b0;
    end else begin
      a_q    <= a_d;
      n_q    <= n_d;
      wide_q <= wide_d;
    end
  end

  assign wide_o = wide_d;
  assign plus_o = a_d != '0;
  assign wrap_o = run_i && tick_i && last;
endmodule

// File: rtl/psd_ref_div.sv
module psd_ref_div #(
  parameter int unsigned R_W = 14
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [R_W-1:0] r_i,
  output logic           pulse_o
);
  logic [R_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      if (!run_i || cnt_q == '0) cnt_q <= r_i - R_W'(1);
      else                       cnt_q <= cnt_q - R_W'(1);
      pulse_o <= run_i && (cnt_q == '0);
    end
  end
endmodule

// File: rtl/psd_divider.sv
module psd_divider #(
  parameter int unsigned P_BASE = 8,
  parameter int unsigned A_W    = 7,
  parameter int unsigned N_W    = 11,
  parameter int unsigned R_W    = 14
) (
  input  logic           clk_i,
  input  logic           ref_clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           sel_narrow_i,
  input  logic [A_W-1:0] a_i,
  input  logic [N_W-1:0] n_i,
  input  logic [R_W-1:0] r_i,
  output logic           fp_o,
  output logic           fr_o,
  output logic           cfg_err_o
);
  logic [A_W-1:0] a_eff;
  logic [N_W-1:0] n_eff;
  logic [R_W-1:0] r_eff;
  logic           wide, plus, tick, wrap;

  psd_cfg_guard #(.A_W(A_W), .N_W(N_W), .R_W(R_W)) u_guard (
    .a_i(a_i), .n_i(n_i), .r_i(r_i),
    .a_o(a_eff), .n_o(n_eff), .r_o(r_eff), .err_o(cfg_err_o)
  );

  psd_prescaler #(.P_BASE(P_BASE)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en_i),
    .wide_i(wide), .plus_i(plus), .tick_o(tick)
  );

  psd_swallow_ctl #(.A_W(A_W), .N_W(N_W)) u_swal (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en_i), .tick_i(tick),
    .narrow_i(sel_narrow_i), .a_i(a_eff), .n_i(n_eff),
    .wide_o(wide), .plus_o(plus), .wrap_o(wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fp_o <= 1'b0;
    else         fp_o <= wrap;
  end

  psd_ref_div #(.R_W(R_W)) u_ref (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .run_i(en_i),
    .r_i(r_eff), .pulse_o(fr_o)
  );
endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk #(
  parameter int unsigned A_W = 7,
  parameter int unsigned N_W = 11,
  parameter int unsigned R_W = 14
) (
  input logic           clk_i,
  input logic           ref_clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic [A_W-1:0] a_i,
  input logic [N_W-1:0] n_i,
  input logic [R_W-1:0] r_i,
  input logic           fp_o,
  input logic           fr_o,
  input logic           cfg_err_o
);
  a_r5_fp_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_o |=> !fp_o);

  a_r5_fr_one_cycle: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    fr_o |=> !fr_o);

  a_r10_fp_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !fp_o);

  a_r10_fr_quiet: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !en_i |=> !fr_o);

  a_r7_n_low_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_i < N_W'(3)) |-> cfg_err_o);

  a_r8_r_low_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_i < R_W'(3)) |-> cfg_err_o);

  a_r9_a_high_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((n_i >= N_W'(3)) && (N_W'(a_i) >= n_i)) |-> cfg_err_o);
endmodule

bind psd_divider psd_divider_chk #(.A_W(A_W), .N_W(N_W), .R_W(R_W)) u_chk (
  .clk_i(clk_i), .ref_clk_i(ref_clk_i), .rst_ni(rst_ni), .en_i(en_i),
  .a_i(a_i), .n_i(n_i), .r_i(r_i),
  .fp_o(fp_o), .fr_o(fr_o), .cfg_err_o(cfg_err_o)
);

// File: tb/psd_divider_tb_top.sv
module psd_divider_tb_top;
  localparam int P_BASE = 8;
  localparam int A_W = 7;
  localparam int N_W = 11;
  localparam int R_W = 14;

  typedef struct {
    int    period;
    string tag;
  } exp_t;

  logic clk_i = 1'b0, ref_clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i = 1'b0, sel_narrow_i = 1'b1;
  logic [A_W-1:0] a_i = A_W'(2);
  logic [N_W-1:0] n_i = N_W'(3);
  logic [R_W-1:0] r_i = R_W'(5);
  logic fp_o, fr_o, cfg_err_o;

  int checks = 0, errors = 0;
  exp_t q_fp[$];
  exp_t q_fr[$];
  int fp_left = 0, fr_left = 0;
  int fp_seen = 0, fr_seen = 0;
  int fp_cnt = 0, fr_cnt = 0;
  bit fp_prev = 0, fr_prev = 0, fp_wide = 0, fr_wide = 0;
  int cur_fp, cur_fr;
  exp_t e_fp, e_fr;

  always #5  clk_i = ~clk_i;      // 100 MHz
  always #20 ref_clk_i = ~ref_clk_i;

  psd_divider #(.P_BASE(P_BASE), .A_W(A_W), .N_W(N_W), .R_W(R_W)) dut_i (
    .clk_i(clk_i), .ref_clk_i(ref_clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .sel_narrow_i(sel_narrow_i), .a_i(a_i), .n_i(n_i), .r_i(r_i),
    .fp_o(fp_o), .fr_o(fr_o), .cfg_err_o(cfg_err_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fp_model(input bit narrow, input int a, input int n);
    int p, ne, ae;
    p  = narrow ? P_BASE : 2 * P_BASE;
    ne = (n < 3) ? 3 : n;
    ae = (a < ne) ? a : 0;
    return p * ne + ae;
  endfunction

  // monitors: measure pulse intervals, compare against queued expectations
  always @(negedge clk_i) if (rst_ni) begin
    fp_cnt++;
    if (fp_o && fp_prev) fp_wide = 1;
    if (fp_o) begin
      if (q_fp.size() > 0) begin
        e_fp = q_fp.pop_front();
        check(fp_cnt == e_fp.period, e_fp.tag, fp_cnt, e_fp.period);
        fp_left--;
      end
      fp_cnt = 0;
      fp_seen++;
    end
    fp_prev = fp_o;
  end

  always @(negedge ref_clk_i) if (rst_ni) begin
    fr_cnt++;
    if (fr_o && fr_prev) fr_wide = 1;
    if (fr_o) begin
      if (q_fr.size() > 0) begin
        e_fr = q_fr.pop_front();
        check(fr_cnt == e_fr.period, e_fr.tag, fr_cnt, e_fr.period);
        fr_left--;
      end
      fr_cnt = 0;
      fr_seen++;
    end
    fr_prev = fr_o;
  end

  task automatic push_fp(input int per, input string tag, input int times);
    repeat (times) begin
      q_fp.push_back('{per, tag});
      fp_left++;
    end
  endtask

  task automatic push_fr(input int per, input string tag, input int times);
    repeat (times) begin
      q_fr.push_back('{per, tag});
      fr_left++;
    end
  endtask

  // change setting just after a pulse: in-flight period keeps the old ratio
  task automatic set_fp(input bit narrow, input int a, input int n, input string tag,
                        input int times, input bit exp_err);
    int k;
    wait (fp_left == 0);
    k = fp_seen;
    wait (fp_seen != k);
    sel_narrow_i = narrow;
    a_i = A_W'(a);
    n_i = N_W'(n);
    #1;
    check(cfg_err_o == exp_err, {tag, " error flag"}, int'(cfg_err_o), int'(exp_err));
    push_fp(cur_fp, "R6 in-flight period", 1);
    cur_fp = fp_model(narrow, a, n);
    push_fp(cur_fp, tag, times);
    wait (fp_left == 0);
  endtask

  task automatic set_fr(input int r, input string tag, input int times, input bit exp_err);
    int k;
    wait (fr_left == 0);
    k = fr_seen;
    wait (fr_seen != k);
    r_i = R_W'(r);
    #1;
    check(cfg_err_o == exp_err, {tag, " error flag"}, int'(cfg_err_o), int'(exp_err));
    push_fr(cur_fr, "R6 in-flight reference period", 1);
    cur_fr = (r < 3) ? 3 : r;
    push_fr(cur_fr, tag, times);
    wait (fr_left == 0);
  endtask

  initial begin
    int k, hits;
    repeat (4) @(negedge clk_i);
    // R11: quiet outputs while in reset
    check(fp_o == 1'b0, "R11 fp_o in reset", int'(fp_o), 0);
    check(fr_o == 1'b0, "R11 fr_o in reset", int'(fr_o), 0);
    check(cfg_err_o == 1'b0, "R9 legal setting flag", int'(cfg_err_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    cur_fp = fp_model(1'b1, 2, 3);
    cur_fr = 5;
    en_i = 1'b1;

    set_fp(1'b1, 2, 3, "R1 narrow A=2 N=3", 3, 1'b0);      // 26
    set_fp(1'b1, 7, 10, "R1 narrow A=7 N=10", 2, 1'b0);    // 87
    set_fp(1'b1, 0, 5, "R3 narrow A=0 N=5", 2, 1'b0);      // 40
    set_fp(1'b0, 3, 4, "R2 wide A=3 N=4", 2, 1'b0);        // 67
    set_fp(1'b0, 0, 3, "R3 wide A=0 N=3", 2, 1'b0);        // 48
    set_fp(1'b1, 2, 1, "R7 N=1 clamped to 3", 2, 1'b1);    // 26
    set_fp(1'b1, 5, 4, "R9 A>=N swallow cleared", 2, 1'b1); // 32
    set_fp(1'b1, 1, 6, "R9 legal setting", 1, 1'b0);       // 49

    set_fr(9, "R4 reference R=9", 3, 1'b0);
    set_fr(2, "R8 R=2 clamped to 3", 3, 1'b1);
    set_fr(6, "R4 reference R=6", 2, 1'b0);

    // R10: disabled window
    wait (fp_left == 0);
    @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    hits = 0;
    repeat (80) begin
      @(negedge clk_i);
      if (fp_o || fr_o) hits++;
    end
    check(hits == 0, "R10 no pulses while disabled", hits, 0);
    en_i = 1'b1;
    k = fp_seen;
    wait (fp_seen != k);
    push_fp(cur_fp, "R10 interval after re-enable", 2);
    wait (fp_left == 0);
    k = fr_seen;
    wait (fr_seen != k);
    push_fr(cur_fr, "R10 reference after re-enable", 2);
    wait (fr_left == 0);

    check(!fp_wide, "R5 fp_o width one cycle", int'(fp_wide), 0);
    check(!fr_wide, "R5 fr_o width one cycle", int'(fr_wide), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule